// File: doc/BRIEF.md
# Internal Transport Header Shim

This block sits on a 64-bit valid/ready packet stream with per-byte keep and a last flag. It has two independent paths. On the ingress path it builds a 64-byte internal header from per-packet forwarding fields. The first 16 bytes, the transport header, go out as two whole beats ahead of the payload toward the fabric. The other 48 bytes leave on a metadata sideband as a one-cycle strobe that the egress forwarding engine picks up.

On the egress path it removes the leading transport header beats from every packet, so the frame reaches the output port exactly as it arrived. Both paths are combinational pass-throughs with a small beat counter. Downstream backpressure stalls them without losing or repeating a byte.

The per-packet fields (`dst_port_i`, `qos_grp_i`, `res_type_i`, `pkt_len_i`, `meta_i`) are sampled with the packet's first payload beat. They must stay stable, with `ing_valid_i` high, until that beat is accepted.

Top module: `ihdr_shim`

## Requirements
- R1: After reset no output is valid and the sideband strobe is low. `ing_ready_o` is low because a header is pending, and `egr_ready_o` is high because the strip path is waiting to drop a header.
- R2: For each ingress packet of N payload beats, `fab_*` carries exactly N+2 beats: two transport header beats and then the payload beats in order. After a payload beat with last set, the next packet starts again with its header.
- R3: Transport header layout, with beat 0 first:
  - beat 0 bits [7:0] hold the destination port, bits [10:8] the QoS group and bits [14:11] the result type.
  - beat 0 bit 15 is zero, bits [29:16] hold the 14-bit packet length, and bits [63:30] are zero.
  - beat 1 is all zeros.
  - Both header beats have keep 8'hFF and last 0.
- R4: While a packet's header beats are still pending on `fab_*`, `ing_ready_o` is low, so no payload beat is consumed.
- R5: `side_valid_o` pulses for exactly one cycle per packet, in the cycle the first header beat is transferred. In that cycle `side_meta_o` equals the 384-bit `meta_i`.
- R6: On the egress path the first two beats of every packet are consumed with `egr_ready_o` high whatever the state of `tx_ready_i`, and they never appear on `tx_*`.
- R7: Egress beats after the first two are forwarded on `tx_*` with data, keep and last unchanged and in order.
- R8: When `fab_ready_i` or `tx_ready_i` is low while the matching output is valid, that output stays valid with unchanged data in the next cycle. No byte is lost or duplicated.
- R9: The final beat of each packet keeps its last flag and its partial keep value (any of 8'hFF down to 8'h01) through both prepend and strip.
- R10: An egress packet whose last flag arrives within its first two beats is discarded entirely, and the following beat starts a new packet.
- R11: A single-beat ingress packet yields exactly three fabric beats, with the last flag on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ing_valid_i | input | 1 | Ingress beat valid |
| ing_ready_o | output | 1 | Ingress beat accepted |
| ing_data_i | input | 64 | Ingress payload data |
| ing_keep_i | input | 8 | Ingress byte enables |
| ing_last_i | input | 1 | Ingress final beat |
| dst_port_i | input | 8 | Destination port for header |
| qos_grp_i | input | 3 | QoS group for header |
| res_type_i | input | 4 | Forwarding result type for header |
| pkt_len_i | input | 14 | Packet length in bytes for header |
| meta_i | input | 384 | 48-byte forwarding metadata |
| fab_valid_o | output | 1 | Fabric beat valid |
| fab_ready_i | input | 1 | Fabric beat accepted |
| fab_data_o | output | 64 | Fabric data (header or payload) |
| fab_keep_o | output | 8 | Fabric byte enables |
| fab_last_o | output | 1 | Fabric final beat |
| side_valid_o | output | 1 | Metadata sideband strobe |
| side_meta_o | output | 384 | Metadata sideband value |
| egr_valid_i | input | 1 | Egress beat valid |
| egr_ready_o | output | 1 | Egress beat accepted |
| egr_data_i | input | 64 | Egress data with header |
| egr_keep_i | input | 8 | Egress byte enables |
| egr_last_i | input | 1 | Egress final beat |
| tx_valid_o | output | 1 | Port beat valid |
| tx_ready_i | input | 1 | Port beat accepted |
| tx_data_o | output | 64 | Port data without header |
| tx_keep_o | output | 8 | Port byte enables |
| tx_last_o | output | 1 | Port final beat |

## Verification
The whole state of each path is a beat position within the current packet. If that position drifts, the next transfer on `fab_*` or `tx_*` shows it at once. A header word appears where payload was expected, or a payload beat is missing or duplicated, or a dropped header beat leaks out. The sideband strobe fires at the wrong beat, or `ing_ready_o` rises while header beats are still pending. The prepend output is looped into the strip input, so every frame must come back byte-identical on `tx_*`. Malformed short packets are then driven straight into the strip path to check that its position recovers on the next packet boundary.

// File: rtl/ihdr_pkg.sv
package ihdr_pkg;
  localparam int HDR_BYTES  = 16;
  localparam int META_BYTES = 48;
  localparam int PORT_W     = 8;
  localparam int QOS_W      = 3;
  localparam int RTYPE_W    = 4;
  localparam int LEN_W      = 14;
  localparam int HDR_W      = HDR_BYTES * 8;
  localparam int META_W     = META_BYTES * 8;
  localparam int PAD_W      = HDR_W - PORT_W - QOS_W - RTYPE_W - 1 - LEN_W;

  // LSB first: beat 0 carries the low 64 bits
  typedef struct packed {
    logic [PAD_W-1:0]   pad;
    logic [LEN_W-1:0]   len;
    logic               rsvd;
    logic [RTYPE_W-1:0] rtype;
    logic [QOS_W-1:0]   qos;
    logic [PORT_W-1:0]  dport;
  } thdr_t;
endpackage

// File: rtl/ihdr_hdr_build.sv
module ihdr_hdr_build
  import ihdr_pkg::*;
(
  input  logic [PORT_W-1:0]  dst_port_i,
  input  logic [QOS_W-1:0]   qos_grp_i,
  input  logic [RTYPE_W-1:0] res_type_i,
  input  logic [LEN_W-1:0]   pkt_len_i,
  output logic [HDR_W-1:0]   hdr_o
);
  thdr_t h;

  always_comb begin
    h       = '0;
    h.dport = dst_port_i;
    h.qos   = qos_grp_i;
    h.rtype = res_type_i;
    h.len   = pkt_len_i;
    hdr_o   = h;
  end
endmodule

// File: rtl/ihdr_prepend.sv
module ihdr_prepend
  import ihdr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic [DATA_W/8-1:0] in_keep_i,
  input  logic                in_last_i,
  input  logic [HDR_W-1:0]    hdr_i,
  input  logic [META_W-1:0]   meta_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [DATA_W-1:0]   out_data_o,
  output logic [DATA_W/8-1:0] out_keep_o,
  output logic                out_last_o,
  output logic                side_valid_o,
  output logic [META_W-1:0]   side_meta_o
);
  localparam int KEEP_W    = DATA_W / 8;
  localparam int HDR_BEATS = HDR_W / DATA_W;
  localparam int CNT_W     = $clog2(HDR_BEATS + 1);
  localparam int IDX_W     = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

  logic [HDR_BEATS-1:0][DATA_W-1:0] hdr_beats;
  logic [CNT_W-1:0] cnt_q;
  logic             in_hdr;
  logic             fire;

  assign hdr_beats = hdr_i;
  assign in_hdr    = (cnt_q < CNT_W'(HDR_BEATS));
  assign fire      = out_valid_o && out_ready_i;

  // header beats wait for the first payload beat so its fields are present
  assign out_valid_o  = in_valid_i;
  assign out_data_o   = in_hdr ? hdr_beats[cnt_q[IDX_W-1:0]] : in_data_i;
  assign out_keep_o   = in_hdr ? {KEEP_W{1'b1}} : in_keep_i;
  assign out_last_o   = in_hdr ? 1'b0 : in_last_i;
  assign in_ready_o   = !in_hdr && out_ready_i;
  assign side_valid_o = fire && (cnt_q == '0);
  assign side_meta_o  = meta_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (fire && in_hdr)     cnt_q <= cnt_q + 1'b1;
    else if (fire && in_last_i)  cnt_q <= '0;
  end

  a_r5_side_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_valid_o |=> !side_valid_o);
  a_r2_hdr_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && out_last_o) |=> !in_ready_o);
  a_r8_fab_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
endmodule

// File: rtl/ihdr_strip.sv
module ihdr_strip
  import ihdr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic [DATA_W/8-1:0] in_keep_i,
  input  logic                in_last_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [DATA_W-1:0]   out_data_o,
  output logic [DATA_W/8-1:0] out_keep_o,
  output logic                out_last_o
);
  localparam int HDR_BEATS = HDR_W / DATA_W;
  localparam int CNT_W     = $clog2(HDR_BEATS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             dropping;
  logic             fire_in;

  assign dropping    = (cnt_q < CNT_W'(HDR_BEATS));
  assign in_ready_o  = dropping || out_ready_i;
  assign out_valid_o = in_valid_i && !dropping;
  assign out_data_o  = in_data_i;
  assign out_keep_o  = in_keep_i;
  assign out_last_o  = in_last_i;
  assign fire_in     = in_valid_i && in_ready_o;

  // last inside the header resets too: a short packet is dropped whole
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (fire_in && in_last_i) cnt_q <= '0;
    else if (fire_in && dropping)  cnt_q <= cnt_q + 1'b1;
  end

  a_r6_drop_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_in && in_last_i) |=> (!out_valid_o && in_ready_o));
  a_r8_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_keep_o)));
endmodule

// File: rtl/ihdr_shim.sv
module ihdr_shim
  import ihdr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ing_valid_i,
  output logic                ing_ready_o,
  input  logic [DATA_W-1:0]   ing_data_i,
  input  logic [DATA_W/8-1:0] ing_keep_i,
  input  logic                ing_last_i,
  input  logic [PORT_W-1:0]   dst_port_i,
  input  logic [QOS_W-1:0]    qos_grp_i,
  input  logic [RTYPE_W-1:0]  res_type_i,
  input  logic [LEN_W-1:0]    pkt_len_i,
  input  logic [META_W-1:0]   meta_i,
  output logic                fab_valid_o,
  input  logic                fab_ready_i,
  output logic [DATA_W-1:0]   fab_data_o,
  output logic [DATA_W/8-1:0] fab_keep_o,
  output logic                fab_last_o,
  output logic                side_valid_o,
  output logic [META_W-1:0]   side_meta_o,
  input  logic                egr_valid_i,
  output logic                egr_ready_o,
  input  logic [DATA_W-1:0]   egr_data_i,
  input  logic [DATA_W/8-1:0] egr_keep_i,
  input  logic                egr_last_i,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic [DATA_W-1:0]   tx_data_o,
  output logic [DATA_W/8-1:0] tx_keep_o,
  output logic                tx_last_o
);
  logic [HDR_W-1:0] hdr;

  ihdr_hdr_build u_build (
    .dst_port_i (dst_port_i),
    .qos_grp_i  (qos_grp_i),
    .res_type_i (res_type_i),
    .pkt_len_i  (pkt_len_i),
    .hdr_o      (hdr)
  );

  ihdr_prepend #(.DATA_W(DATA_W)) u_prepend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (ing_valid_i),
    .in_ready_o   (ing_ready_o),
    .in_data_i    (ing_data_i),
    .in_keep_i    (ing_keep_i),
    .in_last_i    (ing_last_i),
    .hdr_i        (hdr),
    .meta_i       (meta_i),
    .out_valid_o  (fab_valid_o),
    .out_ready_i  (fab_ready_i),
    .out_data_o   (fab_data_o),
    .out_keep_o   (fab_keep_o),
    .out_last_o   (fab_last_o),
    .side_valid_o (side_valid_o),
    .side_meta_o  (side_meta_o)
  );

  ihdr_strip #(.DATA_W(DATA_W)) u_strip (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (egr_valid_i),
    .in_ready_o  (egr_ready_o),
    .in_data_i   (egr_data_i),
    .in_keep_i   (egr_keep_i),
    .in_last_i   (egr_last_i),
    .out_valid_o (tx_valid_o),
    .out_ready_i (tx_ready_i),
    .out_data_o  (tx_data_o),
    .out_keep_o  (tx_keep_o),
    .out_last_o  (tx_last_o)
  );
endmodule

// File: tb/ihdr_shim_tb.sv
module ihdr_shim_tb;
  localparam time HALF = 2.5ns;

  logic clk = 0, rst_n = 0;
  always #HALF clk = ~clk;

  logic         ing_valid = 0, ing_last = 0, ing_ready;
  logic [63:0]  ing_data = '0;
  logic [7:0]   ing_keep = '0;
  logic [7:0]   dport = '0;
  logic [2:0]   qos = '0;
  logic [3:0]   rtype = '0;
  logic [13:0]  plen = '0;
  logic [383:0] meta = '0;
  logic         fab_valid, fab_last, side_valid;
  logic [63:0]  fab_data;
  logic [7:0]   fab_keep;
  logic [383:0] side_meta;
  logic         tx_valid, tx_last, egr_ready;
  logic [63:0]  tx_data;
  logic [7:0]   tx_keep;
  logic         tx_ready = 0;

  // egress input: loopback from fabric, or driven directly
  logic         direct = 0;
  logic         d_valid = 0, d_last = 0;
  logic [63:0]  d_data = '0;
  logic [7:0]   d_keep = '0;
  logic         egr_valid, egr_last, fab_ready;
  logic [63:0]  egr_data;
  logic [7:0]   egr_keep;
  assign egr_valid = direct ? d_valid : fab_valid;
  assign egr_data  = direct ? d_data  : fab_data;
  assign egr_keep  = direct ? d_keep  : fab_keep;
  assign egr_last  = direct ? d_last  : fab_last;
  assign fab_ready = direct ? 1'b1    : egr_ready;

  ihdr_shim u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ing_valid_i(ing_valid), .ing_ready_o(ing_ready), .ing_data_i(ing_data),
    .ing_keep_i(ing_keep), .ing_last_i(ing_last),
    .dst_port_i(dport), .qos_grp_i(qos), .res_type_i(rtype), .pkt_len_i(plen), .meta_i(meta),
    .fab_valid_o(fab_valid), .fab_ready_i(fab_ready), .fab_data_o(fab_data),
    .fab_keep_o(fab_keep), .fab_last_o(fab_last),
    .side_valid_o(side_valid), .side_meta_o(side_meta),
    .egr_valid_i(egr_valid), .egr_ready_o(egr_ready), .egr_data_i(egr_data),
    .egr_keep_i(egr_keep), .egr_last_i(egr_last),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_keep_o(tx_keep), .tx_last_o(tx_last)
  );

  int vectors = 0, errors = 0;
  logic [72:0]  q_fab[$];
  logic [72:0]  q_tx[$];
  logic [383:0] q_meta[$];
  int           fab_idx = 0;
  bit           checking = 0;
  bit           tx_random = 1;

  task automatic chk(input bit ok, input string req, input logic [383:0] act, input logic [383:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  always @(negedge clk) tx_ready <= tx_random ? ($urandom_range(0, 9) < 7) : 1'b1;

  // per-clock reference comparison
  bit           p_fab_stall = 0, p_tx_stall = 0;
  logic [63:0]  p_fab_data, p_tx_data;
  always @(negedge clk) begin
    #2;
    if (checking) begin
      if (p_fab_stall)
        chk(fab_valid && fab_data == p_fab_data, "R8 fab hold", {fab_valid, fab_data}, {1'b1, p_fab_data});
      if (p_tx_stall)
        chk(tx_valid && tx_data == p_tx_data, "R8 tx hold", {tx_valid, tx_data}, {1'b1, p_tx_data});
      if (fab_valid && fab_ready) begin
        logic [72:0] e;
        e = (q_fab.size() > 0) ? q_fab.pop_front() : 73'h1_FF_DEADBEEF_DEADBEEF;
        chk({fab_last, fab_keep, fab_data} == e, "R2/R3/R9/R11 fab beat", {fab_last, fab_keep, fab_data}, e);
        if (fab_idx < 2)
          chk(!ing_ready, "R4 ingress held during header", ing_ready, 0);
        if (fab_idx == 0) begin
          logic [383:0] m;
          m = (q_meta.size() > 0) ? q_meta.pop_front() : '1;
          chk(side_valid && side_meta == m, "R5 sideband strobe", {side_valid, side_meta}, {1'b1, m});
        end else
          chk(!side_valid, "R5 sideband single pulse", side_valid, 0);
        fab_idx = fab_last ? 0 : fab_idx + 1;
      end else
        chk(!side_valid, "R5 sideband idle", side_valid, 0);
      if (tx_valid && tx_ready) begin
        logic [72:0] e;
        e = (q_tx.size() > 0) ? q_tx.pop_front() : 73'h1_FF_DEADBEEF_DEADBEEF;
        chk({tx_last, tx_keep, tx_data} == e, "R6/R7/R9/R10 tx beat", {tx_last, tx_keep, tx_data}, e);
      end
    end
    p_fab_stall = fab_valid && !fab_ready;
    p_fab_data  = fab_data;
    p_tx_stall  = tx_valid && !tx_ready;
    p_tx_data   = tx_data;
  end

  task automatic ing_beat(input logic [63:0] d, input logic [7:0] k, input bit l);
    bit acc;
    @(negedge clk);
    ing_valid = 1; ing_data = d; ing_keep = k; ing_last = l;
    #1 acc = ing_ready;
    @(posedge clk);
    while (!acc) begin
      @(negedge clk); #1 acc = ing_ready; @(posedge clk);
    end
  endtask

  task automatic egr_beat(input logic [63:0] d, input logic [7:0] k, input bit l);
    bit acc;
    @(negedge clk);
    d_valid = 1; d_data = d; d_keep = k; d_last = l;
    #1 acc = egr_ready;
    @(posedge clk);
    while (!acc) begin
      @(negedge clk); #1 acc = egr_ready; @(posedge clk);
    end
  endtask

  task automatic send_pkt(input int nb, input int tail);
    logic [7:0]  lk;
    logic [63:0] h0;
    lk    = 8'hFF >> tail;
    dport = 8'($urandom); qos = 3'($urandom); rtype = 4'($urandom);
    plen  = 14'((nb - 1) * 8 + $countones(lk));
    for (int i = 0; i < 12; i++) meta[i*32 +: 32] = $urandom;
    // R3: expected header from the field layout
    h0 = 64'(dport) | (64'(qos) << 8) | (64'(rtype) << 11) | (64'(plen) << 16);
    q_fab.push_back({1'b0, 8'hFF, h0});
    q_fab.push_back({1'b0, 8'hFF, 64'h0});
    q_meta.push_back(meta);
    for (int b = 0; b < nb; b++) begin
      logic [63:0] d;
      logic [7:0]  k;
      bit          l;
      d = {$urandom, $urandom};
      l = (b == nb - 1);
      k = l ? lk : 8'hFF;
      q_fab.push_back({l, k, d});
      q_tx.push_back({l, k, d});
      ing_beat(d, k, l);
    end
    @(negedge clk);
    ing_valid = 0;
    if ($urandom_range(0, 1) == 1) repeat ($urandom_range(1, 3)) @(negedge clk);
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((q_fab.size() > 0 || q_tx.size() > 0) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state while held in reset
    chk(!fab_valid && !tx_valid && !side_valid, "R1 outputs idle in reset", {fab_valid, tx_valid, side_valid}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!ing_ready, "R1 ingress not ready after reset", ing_ready, 0);
    chk(egr_ready, "R1 egress ready after reset", egr_ready, 1);
    chk(!fab_valid && !tx_valid && !side_valid, "R1 outputs idle after reset", {fab_valid, tx_valid, side_valid}, 0);
    checking = 1;

    // R11 single-beat packet, R9 partial tails, R2 several lengths
    send_pkt(1, 0);
    send_pkt(1, 7);
    send_pkt(2, 3);
    for (int p = 0; p < 24; p++) send_pkt($urandom_range(1, 6), $urandom_range(0, 7));
    wait_drain();
    tx_random = 0;
    for (int p = 0; p < 4; p++) send_pkt($urandom_range(1, 4), p);
    wait_drain();
    tx_random = 1;

    // direct egress: R10 short packets discarded, R6/R7 afterwards
    direct = 1;
    egr_beat(64'h1111, 8'hFF, 1);
    egr_beat(64'h2222, 8'hFF, 0);
    egr_beat(64'h3333, 8'h0F, 1);
    @(negedge clk); d_valid = 0; #1;
    chk(!tx_valid, "R10 short packets produce nothing", tx_valid, 0);
    chk(egr_ready, "R10 strip back at packet start", egr_ready, 1);
    egr_beat(64'hAAAA, 8'hFF, 0);
    egr_beat(64'hBBBB, 8'hFF, 0);
    q_tx.push_back({1'b0, 8'hFF, 64'hC0C0});
    q_tx.push_back({1'b1, 8'h03, 64'hD0D0});
    egr_beat(64'hC0C0, 8'hFF, 0);
    egr_beat(64'hD0D0, 8'h03, 1);
    @(negedge clk); d_valid = 0;
    wait_drain();

    chk(q_fab.size() == 0, "R2 all fabric beats seen", q_fab.size(), 0);
    chk(q_tx.size() == 0, "R7 all port beats seen", q_tx.size(), 0);
    chk(q_meta.size() == 0, "R5 all metadata strobes seen", q_meta.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end
endmodule